// File: doc/BRIEF.md
# Dual-Format Audio Serial Transmitter

This block turns a stereo pair of signed samples into a single serial data line. It runs as a slave: the bit clock and the word-select (channel) clock come from outside. Both are sampled by the system clock, so the whole block lives in one clock domain. On every falling bit-clock edge the block drives the next data bit, and a receiver can capture it on the following rising edge.

A format input selects the framing. In left-justified framing the word starts at the channel boundary. In I2S framing the word starts one bit period later. A word-length input selects 24-bit or 16-bit words. Bits after the end of a word are driven low. The parallel samples arrive with a load strobe and are held until the next frame begins. A load that arrives part-way through a frame therefore does not disturb the frame already being sent.

Top module: `audser_tx`

## Requirements
- R1: Each word is sent in two's complement form, most significant bit first, one bit for each bit-clock falling edge.
- R2: With `fmtI2s`=0, the MSB is driven on the first bit-clock falling edge at which a new word-select level is seen, and word-select high marks the left channel.
- R3: With `fmtI2s`=1, the MSB is driven one bit period after the first falling edge of the new word-select level, and word-select low marks the left channel. If no earlier bit is still pending, the first slot of the half-frame is low.
- R4: With `wordIs16`=1, sample bits [15:0] are sent and bits [23:16] have no effect. With `wordIs16`=0, all 24 bits [23:0] are sent.
- R5: After the last bit of a word, the data line stays low for the rest of that half-frame.
- R6: In I2S framing, when a half-frame is exactly one word long (24-bit words at 48 bit clocks per frame, or 16-bit words at 32), the LSB of a word is sent in the first slot of the next half-frame.
- R7: `sdOut` changes only in response to a bit-clock falling edge and stays stable while the bit clock is high.
- R8: The left word is taken from the held samples at the start of the left half-frame, and the right word is frozen at the same moment. A load during a frame takes effect in the next frame.
- R9: While `rstN` is low, `sdOut` is low and the held samples are cleared to zero, so frames sent after reset and before any load carry all-zero data.
- R10: Frames of 32, 48, 64 and 128 bit clocks work, within the minimums of 48 for 24-bit words and 32 for 16-bit words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | External bit clock |
| lrckIn | input | 1 | External word-select clock, one period per frame |
| fmtI2s | input | 1 | 0 = left-justified framing, 1 = I2S framing |
| wordIs16 | input | 1 | 0 = 24-bit words, 1 = 16-bit words |
| loadStrobe | input | 1 | One-cycle strobe that captures `leftIn` and `rightIn` |
| leftIn | input | 24 | Left sample, two's complement |
| rightIn | input | 24 | Right sample, two's complement |
| sdOut | output | 1 | Serial data output |

## Verification
The properties assume that `fmtI2s` and `wordIs16` do not change while a bit-clock falling edge is being processed. They also assume that each bit-clock phase lasts several system clocks and that word-select changes only together with a falling bit-clock edge. The bench changes the format and word length only while the bit clock sits idle high. It holds each bit-clock phase for four system clocks and moves word-select in the same cycle as the falling bit clock. After every format change it sends two warm-up frames, so that leftover framing from the old setting never reaches a checked frame.

// File: rtl/audser_pkg.sv
`timescale 1ns/1ps
package audser_pkg;

  // Strobes from the sequencing control to the serializer datapath
  typedef struct packed {
    logic fallEdge;    // bit-clock falling edge seen this cycle
    logic halfStart;   // falling edge at which a new word-select level appears
    logic frameStart;  // halfStart into the left channel
    logic leftHalf;    // current word-select level marks the left channel
  } seqStrobe_t;

endpackage

// File: rtl/audser_sync.sv
`timescale 1ns/1ps
module audser_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stage;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage <= {stage[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/audser_ctrl.sv
`timescale 1ns/1ps
module audser_ctrl
  import audser_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkIn,
  input  logic       lrckIn,
  input  logic       fmtI2s,
  output seqStrobe_t strb
);

  logic sclkQ;
  logic lrckQ;
  logic sclkLast;
  logic lrckAtEdge;
  logic fallNow;
  logic newLevel;
  logic leftNow;

  // Both clocks go through equal-depth synchronizers, so a word-select
  // change made with a falling bit clock is seen in the same cycle.
  audser_sync #(.STAGES(SYNC_STAGES)) u_syncSclk (
    .clk(clk), .rstN(rstN), .d(sclkIn), .q(sclkQ)
  );

  audser_sync #(.STAGES(SYNC_STAGES)) u_syncLrck (
    .clk(clk), .rstN(rstN), .d(lrckIn), .q(lrckQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkLast   <= 1'b0;
      lrckAtEdge <= 1'b0;
    end else begin
      sclkLast <= sclkQ;
      if (fallNow) lrckAtEdge <= lrckQ;
    end
  end

  always_comb begin
    fallNow  = sclkLast & ~sclkQ;
    newLevel = fallNow & (lrckQ ^ lrckAtEdge);
    leftNow  = fmtI2s ? ~lrckQ : lrckQ;
    strb.fallEdge   = fallNow;
    strb.halfStart  = newLevel;
    strb.frameStart = newLevel & leftNow;
    strb.leftHalf   = leftNow;
  end

endmodule

// File: rtl/audser_dpath.sv
`timescale 1ns/1ps
module audser_dpath
  import audser_pkg::*;
#(
  parameter int unsigned WORD_BITS  = 24,
  parameter int unsigned SHORT_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strb,
  input  logic                 loadStrobe,
  input  logic [WORD_BITS-1:0] leftIn,
  input  logic [WORD_BITS-1:0] rightIn,
  input  logic                 fmtI2s,
  input  logic                 wordIs16,
  output logic                 sdOut
);

  localparam int unsigned CNT_W = $clog2(WORD_BITS + 1);
  localparam int unsigned PAD   = WORD_BITS - SHORT_BITS;

  logic [WORD_BITS-1:0] pendL;
  logic [WORD_BITS-1:0] pendR;
  logic [WORD_BITS-1:0] actR;
  logic [WORD_BITS-1:0] shifter;
  logic [WORD_BITS-1:0] srcWord;
  logic [WORD_BITS-1:0] aligned;
  logic [CNT_W-1:0]     bitsLeft;
  logic [CNT_W-1:0]     wordLen;
  logic                 sdReg;

  // The left word comes straight from the held sample at frame start;
  // only the right word needs a frozen copy for the second half.
  assign srcWord = strb.leftHalf ? pendL : actR;
  assign wordLen = wordIs16 ? CNT_W'(SHORT_BITS) : CNT_W'(WORD_BITS);

  generate
    if (PAD > 0) begin : g_pad
      assign aligned = wordIs16 ? {srcWord[SHORT_BITS-1:0], {PAD{1'b0}}} : srcWord;
    end else begin : g_nopad
      assign aligned = srcWord;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendL    <= '0;
      pendR    <= '0;
      actR     <= '0;
      shifter  <= '0;
      bitsLeft <= '0;
      sdReg    <= 1'b0;
    end else begin
      if (loadStrobe) begin
        pendL <= leftIn;
        pendR <= rightIn;
      end
      if (strb.frameStart) actR <= pendR;

      if (strb.halfStart) begin
        if (!fmtI2s) begin
          sdReg    <= aligned[WORD_BITS-1];
          shifter  <= {aligned[WORD_BITS-2:0], 1'b0};
          bitsLeft <= wordLen - CNT_W'(1);
        end else begin
          // a bit still owed by the previous word goes out first
          sdReg    <= (bitsLeft != '0) & shifter[WORD_BITS-1];
          shifter  <= aligned;
          bitsLeft <= wordLen;
        end
      end else if (strb.fallEdge) begin
        if (bitsLeft != '0) begin
          sdReg    <= shifter[WORD_BITS-1];
          shifter  <= {shifter[WORD_BITS-2:0], 1'b0};
          bitsLeft <= bitsLeft - CNT_W'(1);
        end else begin
          sdReg <= 1'b0;
        end
      end
    end
  end

  assign sdOut = sdReg;

endmodule

// File: rtl/audser_tx.sv
`timescale 1ns/1ps
module audser_tx
  import audser_pkg::*;
#(
  parameter int unsigned WORD_BITS   = 24,
  parameter int unsigned SHORT_BITS  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclkIn,
  input  logic                 lrckIn,
  input  logic                 fmtI2s,
  input  logic                 wordIs16,
  input  logic                 loadStrobe,
  input  logic [WORD_BITS-1:0] leftIn,
  input  logic [WORD_BITS-1:0] rightIn,
  output logic                 sdOut
);

  seqStrobe_t strb;

  audser_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .lrckIn(lrckIn),
    .fmtI2s(fmtI2s), .strb(strb)
  );

  audser_dpath #(.WORD_BITS(WORD_BITS), .SHORT_BITS(SHORT_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .loadStrobe(loadStrobe),
    .leftIn(leftIn), .rightIn(rightIn), .fmtI2s(fmtI2s),
    .wordIs16(wordIs16), .sdOut(sdOut)
  );

endmodule

// File: rtl/audser_tx_chk.sv
`timescale 1ns/1ps
module audser_tx_chk #(
  parameter int unsigned WORD_BITS  = 24,
  parameter int unsigned SHORT_BITS = 16
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         sdOut,
  input logic                         fmtI2s,
  input logic                         wordIs16,
  input logic                         fallEdge,
  input logic                         halfStart,
  input logic                         frameStart,
  input logic [$clog2(WORD_BITS+1)-1:0] bitsLeft,
  input logic [WORD_BITS-1:0]         actR
);

  localparam int unsigned CNT_W = $clog2(WORD_BITS + 1);

  // R9: output held low during reset
  p_reset_low_r9: assert property (@(posedge clk) !rstN |-> !sdOut)
    else $error("p_reset_low_r9");

  // R7: output only moves after a detected falling bit-clock edge
  p_quiet_between_edges_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(fallEdge) |-> $stable(sdOut))
    else $error("p_quiet_between_edges_r7");

  // R5: once a word is exhausted the line stays low
  p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fallEdge && !halfStart && bitsLeft == '0) |=> !sdOut)
    else $error("p_zero_fill_r5");

  // R2 / R4: left-justified start consumes the MSB immediately
  p_msb_start_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    (halfStart && !fmtI2s) |=>
      bitsLeft == (wordIs16 ? CNT_W'(SHORT_BITS - 1) : CNT_W'(WORD_BITS - 1)))
    else $error("p_msb_start_count_r2");

  // R3 / R4: I2S start keeps the full word pending for one more slot
  p_i2s_start_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    (halfStart && fmtI2s) |=>
      bitsLeft == (wordIs16 ? CNT_W'(SHORT_BITS) : CNT_W'(WORD_BITS)))
    else $error("p_i2s_start_count_r3");

  // R3: I2S first slot is low when nothing is owed
  p_i2s_idle_slot_r3: assert property (@(posedge clk) disable iff (!rstN)
    (halfStart && fmtI2s && bitsLeft == '0) |=> !sdOut)
    else $error("p_i2s_idle_slot_r3");

  // R8: the frozen right word changes only at a frame start
  p_frame_latch_r8: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(actR))
    else $error("p_frame_latch_r8");

endmodule

bind audser_tx audser_tx_chk #(.WORD_BITS(WORD_BITS), .SHORT_BITS(SHORT_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .sdOut(sdOut), .fmtI2s(fmtI2s), .wordIs16(wordIs16),
  .fallEdge(strb.fallEdge), .halfStart(strb.halfStart), .frameStart(strb.frameStart),
  .bitsLeft(u_dpath.bitsLeft), .actR(u_dpath.actR)
);

// File: tb/audser_tx_test.sv
`timescale 1ns/1ps
module audser_tx_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclkIn = 1'b1;
  logic        lrckIn = 1'b0;
  logic        fmtI2s = 1'b0;
  logic        wordIs16 = 1'b0;
  logic        loadStrobe = 1'b0;
  logic [23:0] leftIn = '0;
  logic [23:0] rightIn = '0;
  logic        sdOut;

  int checks = 0;
  int fails = 0;
  int unstable = 0;
  logic [63:0] capL, capR;

  always #5 clk = ~clk;

  audser_tx uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .lrckIn(lrckIn),
    .fmtI2s(fmtI2s), .wordIs16(wordIs16), .loadStrobe(loadStrobe),
    .leftIn(leftIn), .rightIn(rightIn), .sdOut(sdOut)
  );

  // fields: {fmtI2s, wordIs16, bit clocks per frame[7:0], left[23:0], right[23:0]}
  // R10 ratios 32/48/64/128; R4 upper byte set in 16-bit rows must be ignored
  localparam logic [57:0] VEC [10] = '{
    {1'b0, 1'b0, 8'd64,  24'h800001, 24'h7FFFFE},  // R1 R2 sign patterns
    {1'b0, 1'b0, 8'd48,  24'hA5C3E1, 24'h123456},  // R2 word fills half exactly
    {1'b0, 1'b1, 8'd32,  24'hFFBEEF, 24'h55F00D},  // R4 16-bit minimum frame
    {1'b0, 1'b1, 8'd128, 24'h008001, 24'hAA7FFF},  // R5 long zero tail
    {1'b1, 1'b0, 8'd64,  24'hC0FFEE, 24'h3579BD},  // R3 I2S 24-bit
    {1'b1, 1'b0, 8'd48,  24'h900003, 24'h6FFFFD},  // R6 LSB spill 24-bit
    {1'b1, 1'b1, 8'd32,  24'h128001, 24'h347FFF},  // R6 LSB spill 16-bit
    {1'b1, 1'b1, 8'd48,  24'hEE1234, 24'h11ABCD},  // R3 R5 I2S 16 with tail
    {1'b1, 1'b0, 8'd128, 24'hFFFFFF, 24'h000001},  // R3 R10
    {1'b0, 1'b0, 8'd128, 24'h876543, 24'hFEDCBA}   // R2 R10
  };

  function automatic logic [63:0] expHalf(input bit fmt, input bit is16, input int h,
                                          input logic [23:0] w, input logic [23:0] prev);
    int wl;
    logic [63:0] e;
    wl = is16 ? 16 : 24;
    e = '0;
    for (int s = 0; s < h; s++) begin
      if (!fmt) begin
        if (s < wl) e[s] = w[wl-1-s];
      end else if (s == 0) begin
        if (h == wl) e[0] = prev[0];
      end else if (s - 1 < wl) begin
        e[s] = w[wl-s];
      end
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadWords(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    leftIn = l; rightIn = r; loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
  endtask

  // One frame: left half then right half, 8 system clocks per bit slot.
  task automatic runFrame(input bit fmt, input int ratio, input bit doMid,
                          input logic [23:0] mL, input logic [23:0] mR);
    int h;
    logic a, b;
    h = ratio / 2;
    capL = '0; capR = '0;
    for (int half = 0; half < 2; half++) begin
      for (int s = 0; s < h; s++) begin
        @(negedge clk);
        sclkIn = 1'b0;
        if (s == 0) lrckIn = (half == 0) ? ~fmt : fmt;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          loadStrobe = doMid && half == 0 && s == 5 && k == 0;
          if (loadStrobe) begin leftIn = mL; rightIn = mR; end
        end
        @(negedge clk);
        sclkIn = 1'b1;
        @(negedge clk);
        @(negedge clk); a = sdOut;
        @(negedge clk); b = sdOut;
        if (a !== b) unstable++;
        if (half == 0) capL[s] = a; else capR[s] = a;
      end
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(sdOut === 1'b0, "R9 output low in reset", {63'd0, sdOut}, 64'd0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      logic vf, v16;
      int vr;
      logic [23:0] vl, vrt;
      {vf, v16} = VEC[i][57:56];
      vr  = int'(VEC[i][55:48]);
      vl  = VEC[i][47:24];
      vrt = VEC[i][23:0];
      fmtI2s = vf; wordIs16 = v16;
      loadWords(vl, vrt);
      runFrame(vf, vr, 1'b0, '0, '0);
      runFrame(vf, vr, 1'b0, '0, '0);
      runFrame(vf, vr, 1'b0, '0, '0);
      // R1 R4 R5 R10 plus framing R2 (fmt 0) or R3/R6 (fmt 1)
      check(capL === expHalf(vf, v16, vr/2, vl, vrt),
            vf ? "R3 R6 left half I2S" : "R2 R1 left half left-justified",
            capL, expHalf(vf, v16, vr/2, vl, vrt));
      check(capR === expHalf(vf, v16, vr/2, vrt, vl),
            vf ? "R3 R6 right half I2S" : "R2 R5 right half left-justified",
            capR, expHalf(vf, v16, vr/2, vrt, vl));
    end

    // R8: a load in the middle of a frame waits for the next frame
    fmtI2s = 1'b0; wordIs16 = 1'b0;
    loadWords(24'hC0FFEE, 24'h135799);
    runFrame(1'b0, 64, 1'b0, '0, '0);
    runFrame(1'b0, 64, 1'b0, '0, '0);
    runFrame(1'b0, 64, 1'b1, 24'h2468AC, 24'hFEDCBA);
    check(capL === expHalf(0, 0, 32, 24'hC0FFEE, 0), "R8 left before mid load",
          capL, expHalf(0, 0, 32, 24'hC0FFEE, 0));
    check(capR === expHalf(0, 0, 32, 24'h135799, 0), "R8 right keeps old word",
          capR, expHalf(0, 0, 32, 24'h135799, 0));
    runFrame(1'b0, 64, 1'b0, '0, '0);
    check(capL === expHalf(0, 0, 32, 24'h2468AC, 0), "R8 new left next frame",
          capL, expHalf(0, 0, 32, 24'h2468AC, 0));
    check(capR === expHalf(0, 0, 32, 24'hFEDCBA, 0), "R8 new right next frame",
          capR, expHalf(0, 0, 32, 24'hFEDCBA, 0));

    // R9: reset in operation clears the held samples
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(sdOut === 1'b0, "R9 output low during reset", {63'd0, sdOut}, 64'd0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    runFrame(1'b0, 64, 1'b0, '0, '0);
    runFrame(1'b0, 64, 1'b0, '0, '0);
    check(capL === 64'd0, "R9 left zero after reset", capL, 64'd0);
    check(capR === 64'd0, "R9 right zero after reset", capR, 64'd0);

    // R7: output never moved while the bit clock was high
    check(unstable == 0, "R7 stable during high phase", 64'(unstable), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule